// File: doc/BRIEF.md
# Code-Point Priority Table with Indirect Host Access

This block keeps a table of 64 priorities. The 6-bit type-of-service / class-selector code point taken from a received IP frame picks one entry, and that entry gives the frame's forwarding priority. The switch datapath looks up entries through a dedicated port. It presents a code point and gets the stored 3-bit priority back one cycle later.

A host cannot address the table directly. It works through four 32-bit registers, selected by a 2-bit address:

| Address | Register |
|---------|----------|
| 0 | command |
| 1 | write data |
| 2 | read data |
| 3 | status |

To change an entry, the host first places the new priority in the write-data register. It then writes a command word that names the entry and selects a write. To fetch an entry, the host writes a command word with the read select set. It then polls the busy flag in the status register and takes the result from the read-data register once the flag is low. Every command occupies the table for a fixed number of cycles. During that time the busy flag is set and further commands are dropped.

Top module: `dscp_prio_table`

## Requirements
- R1: After reset, all 64 entries hold 0, the busy flag (status register bit 0) is 0, and the command, write-data and read-data registers read as 0.
- R2: The command register (address 0) keeps the entry index in bits 5:0 and the read select in bit 7. Bits 31:8 and bit 6 ignore writes and read as 0.
- R3: A command with bit 7 = 0 stores bits 2:0 of the write-data register, as they stood when the command was accepted, into the indexed entry.
- R4: A command with bit 7 = 1 loads the read-data register (address 2) with the indexed entry, zero-extended to 32 bits. The value is there in the first cycle in which the busy flag reads 0 again.
- R5: The busy flag reads 1 in the cycle after a command is accepted. It stays 1 for exactly 2 cycles and then returns to 0.
- R6: A command written while the busy flag is 1 has no effect. The command register keeps its value and no entry is written.
- R7: The lookup port returns the entry selected by the code point in the cycle after that code point is presented.
- R8: If a lookup and a table write address the same entry in the same cycle, the lookup returns the value that entry held before the write.
- R9: The write-data register (address 1) keeps only bits 2:0; its other bits read as 0. Writes to the read-data register and to the status register (address 3) have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Register select: 0 command, 1 write data, 2 read data, 3 status |
| host_wr | input | 1 | Register write strobe |
| host_wdata | input | 32 | Register write value |
| host_rdata | output | 32 | Value of the selected register (combinational) |
| lk_code | input | 6 | Code point to look up |
| lk_prio | output | 3 | Priority for the code point presented in the previous cycle |

## Verification
The table is exercised in three ways, and each tells a different fault apart:

- **Lookup sweep.** All 64 entries are read back through the lookup port, both after reset and after a pattern of distinct priorities has been written. This separates a wrong index decode or a stuck entry from a correct store.
- **Host command words.** The command words carry set reserved bits and junk above bit 2 of the staged data. This shows whether the field masking holds.
- **Cycle-sensitive cases.** Three cases depend on exact timing:
  - a second command issued while the first is still busy;
  - a new command issued in the first idle cycle;
  - a lookup timed onto the very edge of a table write.

  Together they separate the drop-while-busy rule, the busy-window length and the old-value lookup rule from their near misses.

// File: rtl/dscp_pkg.sv
package dscp_pkg;

   typedef enum logic [1:0] {
      SEL_CMD   = 2'd0,
      SEL_WDATA = 2'd1,
      SEL_RDATA = 2'd2,
      SEL_STAT  = 2'd3
   } reg_sel_e;

   localparam int STAT_BUSY_BIT = 0;

endpackage

// File: rtl/dscp_host_regs.sv
module dscp_host_regs
   import dscp_pkg::*;
#(
   parameter int IDX_W   = 6,
   parameter int PRIO_W  = 3,
   parameter int DATA_W  = 32,
   parameter int RNW_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        host_addr,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              pending,
   input  logic              rd_load,
   input  logic [PRIO_W-1:0] rd_value,
   output logic              cmd_launch,
   output logic              cmd_rnw,
   output logic [IDX_W-1:0]  cmd_idx,
   output logic [PRIO_W-1:0] wdata_prio
);

   generate
      if (RNW_BIT < IDX_W || RNW_BIT >= DATA_W) begin : g_bad_rnw
         $error("dscp_host_regs: RNW_BIT must lie above the index field and inside the word");
      end
      if (PRIO_W > DATA_W) begin : g_bad_prio
         $error("dscp_host_regs: PRIO_W exceeds DATA_W");
      end
   endgenerate

   logic [PRIO_W-1:0] wd_q;
   logic [PRIO_W-1:0] rd_q;
   logic              rnw_q;
   logic [IDX_W-1:0]  idx_q;

   logic wr_cmd, wr_wd;

   assign wr_cmd     = host_wr && (host_addr == SEL_CMD);
   assign wr_wd      = host_wr && (host_addr == SEL_WDATA);
   assign cmd_launch = wr_cmd && !pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rnw_q <= 1'b0;
         idx_q <= '0;
      end else if (cmd_launch) begin
         rnw_q <= host_wdata[RNW_BIT];
         idx_q <= host_wdata[IDX_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wd_q <= '0;
      else if (wr_wd) wd_q <= host_wdata[PRIO_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else if (rd_load) rd_q <= rd_value;
   end

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         SEL_CMD: begin
            host_rdata[IDX_W-1:0] = idx_q;
            host_rdata[RNW_BIT]   = rnw_q;
         end
         SEL_WDATA: host_rdata[PRIO_W-1:0] = wd_q;
         SEL_RDATA: host_rdata[PRIO_W-1:0] = rd_q;
         SEL_STAT:  host_rdata[STAT_BUSY_BIT] = pending;
         default:   host_rdata = '0;
      endcase
   end

   logic unused_bits;
   assign unused_bits = &{1'b0, host_wdata[DATA_W-1:RNW_BIT+1], host_wdata[RNW_BIT-1:IDX_W]};

   assign cmd_rnw    = rnw_q;
   assign cmd_idx    = idx_q;
   assign wdata_prio = wd_q;

endmodule

// File: rtl/dscp_cmd_seq.sv
module dscp_cmd_seq #(
   parameter int PRIO_W     = 3,
   parameter int ACCESS_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              rnw,
   input  logic [PRIO_W-1:0] wdata_prio,
   output logic              pending,
   output logic              tbl_we,
   output logic              tbl_re,
   output logic [PRIO_W-1:0] tbl_wd
);

   localparam int CNT_W = (ACCESS_CYC > 1) ? $clog2(ACCESS_CYC) : 1;

   generate
      if (ACCESS_CYC < 1) begin : g_bad_cyc
         $error("dscp_cmd_seq: ACCESS_CYC must be at least 1");
      end
   endgenerate

   logic              pend_q;
   logic [PRIO_W-1:0] wd_q;
   logic              last;

   generate
      if (ACCESS_CYC == 1) begin : g_single
         assign last = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (launch) cnt_q <= '0;
            else if (pend_q) cnt_q <= cnt_q + 1'b1;
         end
         assign last = (cnt_q == CNT_W'(ACCESS_CYC - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         wd_q   <= '0;
      end else if (launch) begin
         pend_q <= 1'b1;
         wd_q   <= wdata_prio;
      end else if (pend_q && last) begin
         pend_q <= 1'b0;
      end
   end

   assign pending = pend_q;
   assign tbl_we  = pend_q && last && !rnw;
   assign tbl_re  = pend_q && last && rnw;
   assign tbl_wd  = wd_q;

endmodule

// File: rtl/dscp_prio_store.sv
module dscp_prio_store #(
   parameter int IDX_W  = 6,
   parameter int PRIO_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [PRIO_W-1:0] wd,
   output logic [PRIO_W-1:0] host_rd,
   input  logic [IDX_W-1:0]  lk_code,
   output logic [PRIO_W-1:0] lk_prio
);

   localparam int ENTRIES = 1 << IDX_W;

   logic [PRIO_W-1:0] ent [ENTRIES];
   logic [PRIO_W-1:0] lk_q;

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ent[i] <= '0;
            else if (we && (idx == IDX_W'(i)))
               ent[i] <= wd;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lk_q <= '0;
      else        lk_q <= ent[lk_code];
   end

   assign host_rd = ent[idx];
   assign lk_prio = lk_q;

endmodule

// File: rtl/dscp_prio_table.sv
module dscp_prio_table #(
   parameter int IDX_W      = 6,
   parameter int PRIO_W     = 3,
   parameter int DATA_W     = 32,
   parameter int RNW_BIT    = 7,
   parameter int ACCESS_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        host_addr,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic [IDX_W-1:0]  lk_code,
   output logic [PRIO_W-1:0] lk_prio
);

   logic              pending;
   logic              cmd_launch;
   logic              cmd_rnw;
   logic [IDX_W-1:0]  cmd_idx;
   logic [PRIO_W-1:0] wdata_prio;
   logic              tbl_we, tbl_re;
   logic [PRIO_W-1:0] tbl_wd;
   logic [PRIO_W-1:0] host_rd;

   dscp_host_regs #(
      .IDX_W(IDX_W), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .RNW_BIT(RNW_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rdata(host_rdata),
      .pending(pending), .rd_load(tbl_re), .rd_value(host_rd),
      .cmd_launch(cmd_launch), .cmd_rnw(cmd_rnw), .cmd_idx(cmd_idx),
      .wdata_prio(wdata_prio)
   );

   dscp_cmd_seq #(
      .PRIO_W(PRIO_W), .ACCESS_CYC(ACCESS_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .launch(cmd_launch), .rnw(cmd_rnw), .wdata_prio(wdata_prio),
      .pending(pending), .tbl_we(tbl_we), .tbl_re(tbl_re), .tbl_wd(tbl_wd)
   );

   dscp_prio_store #(
      .IDX_W(IDX_W), .PRIO_W(PRIO_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .we(tbl_we), .idx(cmd_idx), .wd(tbl_wd), .host_rd(host_rd),
      .lk_code(lk_code), .lk_prio(lk_prio)
   );

endmodule

// File: rtl/dscp_prio_table_chk.sv
module dscp_prio_table_chk #(
   parameter int IDX_W      = 6,
   parameter int DATA_W     = 32,
   parameter int RNW_BIT    = 7,
   parameter int ACCESS_CYC = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        host_addr,
   input logic              host_wr,
   input logic [DATA_W-1:0] host_rdata,
   input logic              pending,
   input logic              cmd_rnw,
   input logic [IDX_W-1:0]  cmd_idx
);

   localparam int PC_W = $clog2(ACCESS_CYC + 2);

   logic [PC_W-1:0] pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pc_q <= '0;
      else if (pending) pc_q <= pc_q + 1'b1;
      else              pc_q <= '0;
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !pending);

   // R5
   busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == 2'd0 && !pending) |=> pending);

   // R5
   busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_q <= PC_W'(ACCESS_CYC));

   // R5
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pending) |-> (pc_q == PC_W'(ACCESS_CYC)));

   // R6
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && host_wr && host_addr == 2'd0) |=> ($stable(cmd_idx) && $stable(cmd_rnw)));

   // R2
   cmd_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == 2'd0) |-> (host_rdata[DATA_W-1:RNW_BIT+1] == '0 &&
                               host_rdata[RNW_BIT-1:IDX_W] == '0));

endmodule

bind dscp_prio_table dscp_prio_table_chk #(
   .IDX_W(IDX_W), .DATA_W(DATA_W), .RNW_BIT(RNW_BIT), .ACCESS_CYC(ACCESS_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
   .host_rdata(host_rdata), .pending(pending), .cmd_rnw(cmd_rnw), .cmd_idx(cmd_idx)
);

// File: tb/dscp_prio_table_test.sv
module dscp_prio_table_test;

   typedef struct {
      logic [2:0] prio;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  host_addr = 2'd3;
   logic        host_wr = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic [5:0]  lk_code = '0;
   logic [2:0]  lk_prio;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   logic lk_v = 1'b0;
   logic [2:0] model [64];
   exp_t sbq [$];

   always #10 clk = ~clk;

   dscp_prio_table uut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .lk_code(lk_code), .lk_prio(lk_prio)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: each posedge with a lookup in flight produces one result
   always @(posedge clk) begin
      if (lk_v) begin
         #5;
         if (sbq.size() == 0) begin
            checks++; errors++;
            $display("FAIL R7 actual=%h expected=none (empty queue)", lk_prio);
         end else begin
            exp_t e;
            e = sbq.pop_front();
            chk(e.tag, {29'd0, lk_prio}, {29'd0, e.prio});
         end
      end
   end

   // driver: present a code point and queue its expected priority
   task automatic lk_set(logic [5:0] code, logic [2:0] exp, string tag);
      exp_t e;
      lk_code = code;
      lk_v    = 1'b1;
      e.prio  = exp;
      e.tag   = tag;
      sbq.push_back(e);
   endtask

   task automatic sweep(string tag);
      for (int i = 0; i < 64; i++) begin
         lk_set(6'(i), model[i], tag);
         @(negedge clk);
      end
      lk_v = 1'b0;
      @(negedge clk);
   endtask

   task automatic hw(logic [1:0] a, logic [31:0] d);
      host_addr  = a;
      host_wdata = d;
      host_wr    = 1'b1;
      @(negedge clk);
      host_wr    = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, string req, logic [31:0] exp);
      host_addr = a;
      #1;
      chk(req, host_rdata, exp);
   endtask

   // command with busy-flag checks; returns in the first idle cycle
   task automatic cmd(logic rnw, logic [5:0] idx, logic [31:0] junk);
      hw(2'd0, junk | {24'd0, rnw, 1'b0, idx});
      rd(2'd3, "R5", 32'd1);
      @(negedge clk);
      rd(2'd3, "R5", 32'd1);
      @(negedge clk);
      rd(2'd3, "R5", 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) model[i] = 3'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, "R1", 32'd0);
      rd(2'd1, "R1", 32'd0);
      rd(2'd2, "R1", 32'd0);
      rd(2'd3, "R1", 32'd0);
      sweep("R1");

      // R9 write-data masking
      hw(2'd1, 32'hFFFF_FFF5);
      rd(2'd1, "R9", 32'd5);

      // R2 R3: write command with reserved bits set
      cmd(1'b0, 6'd10, 32'hABCD_FF40);
      model[10] = 3'd5;
      rd(2'd0, "R2", 32'h0000_000A);

      // R9: read-data and status ignore writes
      hw(2'd2, 32'hFFFF_FFFF);
      rd(2'd2, "R9", 32'd0);
      hw(2'd3, 32'hFFFF_FFFF);
      rd(2'd3, "R9", 32'd0);

      // R4 read back entry 10, then entry 0
      cmd(1'b1, 6'd10, 32'd0);
      rd(2'd2, "R4", 32'd5);
      rd(2'd0, "R2", 32'h0000_008A);
      cmd(1'b1, 6'd0, 32'h0000_0040);
      rd(2'd2, "R4", 32'd0);

      // R3 R7: pattern fill, back-to-back commands, then full sweep
      for (int i = 0; i < 64; i += 5) begin
         hw(2'd1, 32'(((i * 3) + 1) & 7) | 32'hFFFF_FF00);
         cmd(1'b0, 6'(i), 32'd0);
         model[i] = 3'(((i * 3) + 1) & 7);
      end
      sweep("R3");
      cmd(1'b1, 6'd35, 32'd0);
      rd(2'd2, "R4", {29'd0, model[35]});

      // R6: second command during busy is dropped
      hw(2'd1, 32'd6);
      hw(2'd0, {24'd0, 1'b0, 1'b0, 6'd20});
      hw(2'd1, 32'd2);
      hw(2'd0, {24'd0, 1'b0, 1'b0, 6'd21});
      rd(2'd0, "R6", 32'h0000_0014);
      @(negedge clk);
      rd(2'd3, "R6", 32'd0);
      model[20] = 3'd6;
      lk_set(6'd20, model[20], "R6");
      @(negedge clk);
      lk_set(6'd21, model[21], "R6");
      @(negedge clk);
      lk_v = 1'b0;
      @(negedge clk);

      // R8: lookup on the edge of the table write sees the old value
      hw(2'd1, 32'd7);
      hw(2'd0, {24'd0, 1'b0, 1'b0, 6'd30});
      @(negedge clk);
      lk_set(6'd30, model[30], "R8");
      @(negedge clk);
      model[30] = 3'd7;
      lk_set(6'd30, 3'd7, "R8");
      @(negedge clk);
      lk_v = 1'b0;
      @(negedge clk);

      chk("R7", 32'(sbq.size()), 32'd0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule